// File: doc/BRIEF.md
# Programmable Input Debounce Filter

This block conditions one already-synchronized pad input before it reaches the pad's receive logic. When filtering is switched on, the filtered level only moves to a new value after the raw input has disagreed with the current filtered level for an unbroken stretch of time. That stretch is two raised to a programmed exponent, counted in base ticks. A base tick is a fixed number of system clock cycles, set by a parameter. The default of 7812 cycles at 250 MHz gives a base tick of about 31.25 microseconds.

Filtering needs three conditions at once: the enable bit of the debounce configuration field, a separate glitch-filter select input, and an exponent of at least 3. If any of the three is missing, the block is a one-cycle registered passthrough. The exponent range 3 to 15 gives hold times from 8 to 32768 base ticks. Each filter has its own prescaler, and that prescaler restarts whenever the raw input agrees with the filtered level. The hold time is therefore an exact number of clock cycles, with no phase uncertainty from a shared tick.

Top module: `pad_debounce`

## Requirements
- R1: While the reset input is low, and after it is released, `dout` is 0 until the input moves it.
- R2: With `dbnc_cfg[0]` (enable) at 0, `dout` equals the value `din` had at the previous rising clock edge.
- R3: With enable at 1 but `glitch_sel` at 0, `dout` follows `din` with the same one-cycle latency as R2.
- R4: With enable and `glitch_sel` at 1 and exponent `dbnc_cfg[4:1]` below 3, `dout` follows `din` with one-cycle latency.
- R5: The configuration field is decoded as follows: bit 0 is the enable and bits 4:1 are the exponent E. A legal exponent with bit 0 clear still gives passthrough.
- R6: In filtering mode, `din` may rise from 0 to 1 and hold 1 for H = TICK_DIV * 2^E consecutive clock edges. `dout` then becomes 1 at the H-th edge and not before.
- R7: The same H-edge rule applies to a fall of `din` from 1 to 0.
- R8: In filtering mode, `din` may return to the filtered level before H edges have passed. `dout` then keeps its value, and the count starts again from zero at the next disagreement.
- R9: The largest exponent, 15, gives a hold time of TICK_DIV * 32768 edges.
- R10: The smallest legal exponent, 3, gives a hold time of TICK_DIV * 8 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| din | input | 1 | Synchronized raw pad input |
| dbnc_cfg | input | EXP_W+1 | Bit 0 is the debounce enable; bits EXP_W:1 are the hold exponent |
| glitch_sel | input | 1 | Glitch-filter select; must be 1 together with the enable for filtering |
| dout | output | 1 | Filtered input level |

## Verification
The passthrough modes are driven with a toggling pattern whose transitions are one cycle apart. Any filtering left active by mistake would hold the output still, which shows up as a mismatch. Each mode that should give passthrough is driven separately: enable off, select off, exponent too small, and a legal exponent with the enable clear. This separates a wrongly decoded enable, select or exponent threshold from the others.

In filtering mode, the input holds a new level for exactly H edges, then for H minus one edges, and then returns. This locates the output change on a single edge and shows whether the count restarts after an interrupted run. Rises and falls are tried at the two extreme exponents and at one middle exponent, so errors in the power-of-two limit and in counter width are caught.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

  // Smallest exponent that selects filtering; lower values bypass.
  localparam int unsigned DBF_MIN_EXP = 3;

  typedef enum logic {
    DBF_PASS   = 1'b0,
    DBF_FILTER = 1'b1
  } dbf_mode_e;

  // Resolve the working mode from the three qualifying conditions.
  function automatic dbf_mode_e dbf_mode(input logic en, input logic gsel,
                                         input logic exp_ok);
    return (en && gsel && exp_ok) ? DBF_FILTER : DBF_PASS;
  endfunction

endpackage

// File: rtl/dbf_rst_sync.sv
module dbf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/dbf_prescale.sv
module dbf_prescale #(
  parameter int unsigned TICK_DIV = 7812
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int unsigned PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] pre_d;
  logic          at_last;

  assign at_last = (pre_q == P_LAST);

  // The phase restarts whenever the run condition drops.
  always_comb begin
    pre_d = pre_q;
    if (!run)         pre_d = '0;
    else if (at_last) pre_d = '0;
    else              pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick = run & at_last;

  generate
    if (TICK_DIV > 1) begin : g_spacing
      // Ticks are never back to back when the divider exceeds one.
      assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/dbf_hold_cnt.sv
module dbf_hold_cnt #(
  parameter int unsigned EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [EXP_W-1:0] exp_code,
  output logic             done
);

  localparam int unsigned CNT_W = (1 << EXP_W) - 1;

  logic [CNT_W:0]   span;
  logic [CNT_W-1:0] limit;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             reached;

  // Terminal count is 2^E - 1 ticks past the first counted tick.
  always_comb begin
    span  = (CNT_W+1)'(1) << exp_code;
    limit = CNT_W'(span - 1'b1);
  end

  assign reached = (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)         cnt_d = '0;
    else if (tick)    cnt_d = reached ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = run & tick & reached;

  // A run that is broken leaves no partial count behind.
  assert_count_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

  // Without a tick the count cannot move while the run continues.
  assert_count_only_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/pad_debounce.sv
module pad_debounce #(
  parameter int unsigned TICK_DIV = 7812,
  parameter int unsigned EXP_W    = 4
) (
  input  logic           clk,
  input  logic           arst_n,
  input  logic           din,
  input  logic [EXP_W:0] dbnc_cfg,
  input  logic           glitch_sel,
  output logic           dout
);

  import dbf_pkg::*;

  localparam logic [EXP_W-1:0] EXP_FLOOR = EXP_W'(DBF_MIN_EXP);

  logic             rst_n;
  logic             cfg_en;
  logic [EXP_W-1:0] cfg_exp;
  logic             exp_ok;
  dbf_mode_e        mode;
  logic             filt_on;
  logic             differ;
  logic             run;
  logic             tick;
  logic             hold_done;
  logic             out_q;
  logic             out_d;

  dbf_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n_o(rst_n)
  );

  // Field decode: bit 0 enable, upper bits exponent.
  assign cfg_en  = dbnc_cfg[0];
  assign cfg_exp = dbnc_cfg[EXP_W:1];
  assign exp_ok  = (cfg_exp >= EXP_FLOOR);
  assign mode    = dbf_mode(cfg_en, glitch_sel, exp_ok);
  assign filt_on = (mode == DBF_FILTER);

  assign differ = din ^ out_q;
  assign run    = filt_on & differ;

  dbf_prescale #(.TICK_DIV(TICK_DIV)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  dbf_hold_cnt #(.EXP_W(EXP_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .tick    (tick),
    .exp_code(cfg_exp),
    .done    (hold_done)
  );

  always_comb begin
    out_d = out_q;
    if (!filt_on)       out_d = din;
    else if (hold_done) out_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end

  assign dout = out_q;

  assert_pass_when_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dbnc_cfg[0] |=> (dout == $past(din)));

  assert_pass_without_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dbnc_cfg[0] && !glitch_sel) |=> (dout == $past(din)));

  assert_pass_low_exponent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dbnc_cfg[0] && glitch_sel && (dbnc_cfg[EXP_W:1] < EXP_FLOOR)) |=> (dout == $past(din)));

  assert_hold_on_agree_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_on && (din == dout)) |=> $stable(dout));

  assert_wait_for_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_on && !hold_done) |=> $stable(dout));

endmodule

// File: tb/test_pad_debounce.sv
`timescale 1ns/100ps
module test_pad_debounce;

  localparam int unsigned DIV   = 2;
  localparam int unsigned EXP_W = 4;

  typedef struct {
    int    cyc;
    bit    val;
    string tag;
  } exp_item_t;

  logic           clk = 1'b0;
  logic           arst_n = 1'b0;
  logic           din = 1'b0;
  logic [EXP_W:0] dbnc_cfg = '0;
  logic           glitch_sel = 1'b0;
  logic           dout;

  int        n_cmp = 0;
  int        n_bad = 0;
  int        cyc   = 0;
  exp_item_t sb_q[$];

  // Reference state kept from the requirements.
  bit m_out = 1'b0;
  int m_run = 0;

  pad_debounce #(.TICK_DIV(DIV), .EXP_W(EXP_W)) i_pad_debounce (
    .clk       (clk),
    .arst_n    (arst_n),
    .din       (din),
    .dbnc_cfg  (dbnc_cfg),
    .glitch_sel(glitch_sel),
    .dout      (dout)
  );

  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit act, bit expv, string tag);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: dout=%0b expected=%0b at cycle %0d", tag, act, expv, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Driver: apply inputs for n cycles and queue the value expected after each edge.
  task automatic step(bit d, bit en, bit gsel, int e, int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      din        = d;
      dbnc_cfg   = {4'(e), en};
      glitch_sel = gsel;
      if (!(en && gsel && e >= 3)) begin
        m_out = d;
        m_run = 0;
      end else if (d != m_out) begin
        m_run++;
        if (m_run == DIV * (1 << e)) begin
          m_out = d;
          m_run = 0;
        end
      end else begin
        m_run = 0;
      end
      sb_q.push_back('{cyc: cyc + 1, val: m_out, tag: tag});
    end
  endtask

  // Monitor: compare dout against queued items once their edge has passed.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
        exp_item_t it;
        it = sb_q.pop_front();
        check(dout, it.val, it.tag);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    #5;
    check(dout, 1'b0, "R1 in reset");
    repeat (3) @(posedge clk);
    #1 arst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2 check(dout, 1'b0, "R1 after release");

    // Passthrough, enable clear.
    for (int k = 0; k < 6; k++) step(k[0] ? 1'b0 : 1'b1, 1'b0, 1'b1, 5, 1, "R2");
    // Passthrough, select clear.
    for (int k = 0; k < 6; k++) step(k[0], 1'b1, 1'b0, 5, 1, "R3");
    // Passthrough, exponent 2 and 0.
    for (int k = 0; k < 6; k++) step(~k[0], 1'b1, 1'b1, 2, 1, "R4");
    for (int k = 0; k < 4; k++) step(k[0], 1'b1, 1'b1, 0, 1, "R4");
    // Legal exponent in the field but enable bit clear.
    for (int k = 0; k < 6; k++) step(~k[0], 1'b0, 1'b1, 4, 1, "R5");

    step(1'b0, 1'b1, 1'b1, 3, 4, "R5");
    // Exponent 3: exact rise and fall.
    step(1'b1, 1'b1, 1'b1, 3, DIV * 8 + 3, "R6 R10 rise");
    step(1'b0, 1'b1, 1'b1, 3, DIV * 8 + 3, "R7 R10 fall");
    // Broken runs one edge short, then a full one.
    step(1'b1, 1'b1, 1'b1, 3, DIV * 8 - 1, "R8 short");
    step(1'b0, 1'b1, 1'b1, 3, 1, "R8 return");
    step(1'b1, 1'b1, 1'b1, 3, DIV * 8 - 1, "R8 short again");
    step(1'b0, 1'b1, 1'b1, 3, 2, "R8 return");
    step(1'b1, 1'b1, 1'b1, 3, DIV * 8 + 2, "R8 full after restart");
    // Middle exponent.
    step(1'b0, 1'b1, 1'b1, 5, DIV * 32 + 2, "R7 exp5 fall");
    step(1'b1, 1'b1, 1'b1, 5, DIV * 32 - 1, "R8 exp5 short");
    step(1'b0, 1'b1, 1'b1, 5, 3, "R8 exp5 return");
    step(1'b1, 1'b1, 1'b1, 5, DIV * 32 + 2, "R6 exp5 rise");
    // Largest exponent.
    step(1'b0, 1'b1, 1'b1, 15, DIV * 32768 + 3, "R9 exp15 fall");

    @(posedge clk);
    wait (sb_q.size() == 0);
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule